// File: doc/BRIEF.md
# VT Path Overhead V5 Byte Generator

This block sits in the ingress path of a VT1.5/VT2 mapper. A byte stream of VT superframe data enters with a qualifier and a start-of-superframe marker. The marked byte is the slot of the V5 path overhead byte. The generator replaces that byte with a freshly built V5 and passes every other byte through unchanged. All output is delayed by one clock.

Each V5 carries four things. The first is a two-bit interleaved parity (BIP-2) over everything transmitted in the previous superframe, including that superframe's own V5. The second is a three-bit signal label from configuration. The third is a remote error flag taken from the receive side. The fourth is a pair of remote failure and remote defect indications, each with a selectable source: a software value or the live defect status of the companion receive de-mapper. For test purposes, the parity can be deliberately corrupted. A status output mirrors whether the tributary DS1/E1 signal carries AIS.

Top module: `vt_v5_gen`

## Requirements
- R1: `out_valid` equals `in_valid` one clock later, and `out_sof` equals `in_valid && in_sof` one clock later. `out_data` is updated only for valid bytes and holds otherwise.
- R2: A valid byte without `in_sof` appears unchanged on `out_data` one clock later.
- R3: A valid byte with `in_sof` is replaced by V5 with this layout: `out_data[7:6]` BIP-2, `[5]` REI-V, `[4]` RFI-V, `[3:1]` signal label, `[0]` RDI-V. `out_data[7]` is V5 bit 1, transmitted first. V5 bit 1 is even parity over bits 1,3,5,7 (indices 7,5,3,1) of every byte output since the previous V5, that previous V5 included. V5 bit 2 is the same over bits 2,4,6,8 (indices 6,4,2,0). The first V5 after reset covers only the bytes output since reset.
- R4: With `cfg_bip_err` = 1, both BIP-2 bits are inverted before insertion. The accumulation for the next superframe uses the inverted byte as sent.
- R5: REI-V equals `rx_rei_nonzero`.
- R6: RFI-V equals `cfg_rfi_val` when `cfg_rfi_auto` = 0, and `rx_rfi_defect` when `cfg_rfi_auto` = 1.
- R7: The label field equals `cfg_label`.
- R8: RDI-V is selected by `cfg_rdi_sel`: 00 gives `cfg_rdi_val`, 01 gives `rx_rdi_defect`, 11 gives `rx_rdi_status`, and the reserved code 10 gives 0.
- R9: Every control and defect input that feeds V5 is taken only in the clock where the `in_sof` byte is accepted. Values they hold at any other time have no effect on any output byte.
- R10: `ais_status` equals `trib_ais` one clock later.
- R11: While `rst_n` is low, `out_valid`, `out_sof`, `out_data` and `ais_status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input byte qualifier |
| in_sof | input | 1 | Marks the V5 slot (first byte of a superframe) |
| in_data | input | 8 | Input superframe byte |
| cfg_bip_err | input | 1 | Invert both BIP-2 bits |
| cfg_label | input | 3 | Signal label value |
| cfg_rfi_auto | input | 1 | RFI-V source: 0 software, 1 receive defect |
| cfg_rfi_val | input | 1 | Software RFI-V value |
| cfg_rdi_sel | input | 2 | RDI-V source code |
| cfg_rdi_val | input | 1 | Software RDI-V value |
| rx_rei_nonzero | input | 1 | Receive side reports a nonzero error count |
| rx_rfi_defect | input | 1 | Receive side failure indication |
| rx_rdi_defect | input | 1 | Receive side defect summary for RDI-V |
| rx_rdi_status | input | 1 | Receive block RDI status (code 11) |
| trib_ais | input | 1 | Tributary DS1/E1 carries AIS |
| out_valid | output | 1 | Output byte qualifier |
| out_sof | output | 1 | Output byte is V5 |
| out_data | output | 8 | Output superframe byte |
| ais_status | output | 1 | Read-only AIS status |

## Verification
Every result appears exactly one clock after the input cycle that produced it: the byte, its qualifier, its V5 fields and the AIS status. The bench drives inputs on the falling edge and compares all outputs on the next falling edge with a behavioural model advanced by one clock. The parity in a V5 depends on every byte output since the previous V5. The model therefore keeps a queue of the bytes it expects to have been sent and recounts the parity bit by bit from that queue. Controls change on every clock, including cycles inside a superframe, so a V5 matches only if it uses the values present in its own `in_sof` cycle.

// File: rtl/vt_v5_pkg.sv
package vt_v5_pkg;
  localparam int BYTE_W  = 8;
  localparam int BIP_W   = 2;
  localparam int LABEL_W = 3;

  localparam logic [1:0] RDI_SRC_SW   = 2'b00;
  localparam logic [1:0] RDI_SRC_DEF  = 2'b01;
  localparam logic [1:0] RDI_SRC_RSVD = 2'b10;
  localparam logic [1:0] RDI_SRC_STAT = 2'b11;

  typedef struct packed {
    logic               bip_err;
    logic [LABEL_W-1:0] label;
    logic               rfi_auto;
    logic               rfi_val;
    logic [1:0]         rdi_sel;
    logic               rdi_val;
  } v5_cfg_t;

  typedef struct packed {
    logic rei;
    logic rfi_def;
    logic rdi_def;
    logic rdi_stat;
  } rx_stat_t;
endpackage

// File: rtl/vt_bip2_acc.sv
module vt_bip2_acc
  import vt_v5_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              restart,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [BIP_W-1:0]  bip
);
  logic [BYTE_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (commit) begin
      if (restart) acc_d = byte_in;
      else         acc_d = acc_q ^ byte_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // lane k covers every bit index i with i % BIP_W == k
  for (genvar k = 0; k < BIP_W; k++) begin : g_lane
    always_comb begin
      bip[k] = 1'b0;
      for (int i = k; i < BYTE_W; i += BIP_W) bip[k] = bip[k] ^ acc_q[i];
    end
  end
endmodule

// File: rtl/vt_v5_pack.sv
module vt_v5_pack
  import vt_v5_pkg::*;
(
  input  v5_cfg_t           cfg,
  input  rx_stat_t          rx,
  input  logic [BIP_W-1:0]  bip,
  output logic [BYTE_W-1:0] v5
);
  logic rfi, rdi;
  logic [BIP_W-1:0] bip_tx;

  always_comb begin
    rfi = cfg.rfi_auto ? rx.rfi_def : cfg.rfi_val;
    unique case (cfg.rdi_sel)
      RDI_SRC_SW:   rdi = cfg.rdi_val;
      RDI_SRC_DEF:  rdi = rx.rdi_def;
      RDI_SRC_STAT: rdi = rx.rdi_stat;
      RDI_SRC_RSVD: rdi = 1'b0;
      default:      rdi = 1'b0;
    endcase
    bip_tx = bip ^ {BIP_W{cfg.bip_err}};
    v5     = {bip_tx, rx.rei, rfi, cfg.label, rdi};
  end
endmodule

// File: rtl/vt_v5_gen.sv
module vt_v5_gen
  import vt_v5_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic [7:0]         in_data,
  input  logic               cfg_bip_err,
  input  logic [2:0]         cfg_label,
  input  logic               cfg_rfi_auto,
  input  logic               cfg_rfi_val,
  input  logic [1:0]         cfg_rdi_sel,
  input  logic               cfg_rdi_val,
  input  logic               rx_rei_nonzero,
  input  logic               rx_rfi_defect,
  input  logic               rx_rdi_defect,
  input  logic               rx_rdi_status,
  input  logic               trib_ais,
  output logic               out_valid,
  output logic               out_sof,
  output logic [7:0]         out_data,
  output logic               ais_status
);
  v5_cfg_t           cfg;
  rx_stat_t          rx;
  logic [BIP_W-1:0]  bip;
  logic [BYTE_W-1:0] v5, byte_n;

  logic              valid_q, valid_d;
  logic              sof_q, sof_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              ais_q, ais_d;
  logic              data_en;

  assign cfg = '{bip_err: cfg_bip_err, label: cfg_label, rfi_auto: cfg_rfi_auto,
                 rfi_val: cfg_rfi_val, rdi_sel: cfg_rdi_sel, rdi_val: cfg_rdi_val};
  assign rx  = '{rei: rx_rei_nonzero, rfi_def: rx_rfi_defect,
                 rdi_def: rx_rdi_defect, rdi_stat: rx_rdi_status};

  vt_v5_pack u_pack (.cfg(cfg), .rx(rx), .bip(bip), .v5(v5));

  vt_bip2_acc u_bip (
    .clk(clk), .rst_n(rst_n), .commit(in_valid), .restart(in_sof),
    .byte_in(byte_n), .bip(bip)
  );

  always_comb begin
    byte_n  = in_sof ? v5 : in_data;
    data_en = in_valid;
    valid_d = in_valid;
    sof_d   = in_valid & in_sof;
    data_d  = data_en ? byte_n : data_q;
    ais_d   = trib_ais;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sof_q   <= 1'b0;
      data_q  <= '0;
      ais_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      sof_q   <= sof_d;
      data_q  <= data_d;
      ais_q   <= ais_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_sof    = sof_q;
  assign out_data   = data_q;
  assign ais_status = ais_q;
endmodule

// File: rtl/vt_v5_gen_chk.sv
module vt_v5_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sof,
  input logic [7:0] in_data,
  input logic [2:0] cfg_label,
  input logic [1:0] cfg_rdi_sel,
  input logic       rx_rei_nonzero,
  input logic       trib_ais,
  input logic       out_valid,
  input logic       out_sof,
  input logic [7:0] out_data,
  input logic       ais_status
);
  assert_valid_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_sof && $stable(out_data)));
  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sof) |=> (out_data == $past(in_data) && !out_sof));
  assert_rei_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (out_sof && out_data[5] == $past(rx_rei_nonzero)));
  assert_label_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (out_data[3:1] == $past(cfg_label)));
  assert_rdi_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && cfg_rdi_sel == 2'b10) |=> !out_data[0]);
  assert_ais_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ais_status == $past(trib_ais)));
  always_comb if (!rst_n) assert_reset_R11: assert (!out_valid && !out_sof && out_data == 8'h00 && !ais_status);
endmodule

bind vt_v5_gen vt_v5_gen_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
  .cfg_label(cfg_label), .cfg_rdi_sel(cfg_rdi_sel), .rx_rei_nonzero(rx_rei_nonzero),
  .trib_ais(trib_ais), .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data),
  .ais_status(ais_status)
);

// File: tb/test_vt_v5_gen.sv
`timescale 1ns/1ps
module test_vt_v5_gen;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sof;
  logic [7:0] in_data;
  logic cfg_bip_err, cfg_rfi_auto, cfg_rfi_val, cfg_rdi_val;
  logic [2:0] cfg_label;
  logic [1:0] cfg_rdi_sel;
  logic rx_rei_nonzero, rx_rfi_defect, rx_rdi_defect, rx_rdi_status, trib_ais;
  logic out_valid, out_sof, ais_status;
  logic [7:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference state
  bit       e_valid, e_sof, e_ais;
  bit [7:0] e_data;
  bit [7:0] sent_q[$];

  always #2.5 clk = ~clk;

  vt_v5_gen i_vt_v5_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .cfg_bip_err(cfg_bip_err), .cfg_label(cfg_label), .cfg_rfi_auto(cfg_rfi_auto),
    .cfg_rfi_val(cfg_rfi_val), .cfg_rdi_sel(cfg_rdi_sel), .cfg_rdi_val(cfg_rdi_val),
    .rx_rei_nonzero(rx_rei_nonzero), .rx_rfi_defect(rx_rfi_defect),
    .rx_rdi_defect(rx_rdi_defect), .rx_rdi_status(rx_rdi_status), .trib_ais(trib_ais),
    .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data), .ais_status(ais_status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit [7:0] model_v5();
    int p1 = 0, p2 = 0;
    bit rfi, rdi;
    foreach (sent_q[j]) begin
      for (int pos = 1; pos <= 8; pos++) begin
        if (sent_q[j][8-pos]) begin
          if (pos % 2 == 1) p1++; else p2++;
        end
      end
    end
    if (cfg_bip_err) begin p1++; p2++; end  // R4 inversion
    rfi = cfg_rfi_auto ? rx_rfi_defect : cfg_rfi_val;
    case (cfg_rdi_sel)
      2'd0: rdi = cfg_rdi_val;
      2'd1: rdi = rx_rdi_defect;
      2'd3: rdi = rx_rdi_status;
      default: rdi = 1'b0;
    endcase
    return {bit'(p1 % 2), bit'(p2 % 2), rx_rei_nonzero, rfi, cfg_label, rdi};
  endfunction

  task automatic compare();
    check(out_valid == e_valid, "R1 valid", out_valid, e_valid);
    check(out_sof == e_sof, "R1 sof", out_sof, e_sof);
    check(ais_status == e_ais, "R10 ais", ais_status, e_ais);
    if (e_valid && !e_sof)
      check(out_data == e_data, "R2 passthrough", out_data, e_data);
    else if (e_valid && e_sof) begin
      check(out_data[7:6] == e_data[7:6], "R3 R4 bip2", out_data[7:6], e_data[7:6]);
      check(out_data[5] == e_data[5], "R5 rei", out_data[5], e_data[5]);
      check(out_data[4] == e_data[4], "R6 rfi", out_data[4], e_data[4]);
      check(out_data[3:1] == e_data[3:1], "R7 R9 label", out_data[3:1], e_data[3:1]);
      check(out_data[0] == e_data[0], "R8 rdi", out_data[0], e_data[0]);
    end else
      check(out_data == e_data, "R1 hold", out_data, e_data);
  endtask

  task automatic drive_and_model(input int mode, inout int pos, inout int flen);
    in_valid = ($urandom_range(0, 9) < 8);
    in_sof   = (pos == 0);
    in_data  = 8'($urandom);
    // R9: controls toggle every clock, including mid-superframe
    cfg_bip_err    = (mode == 1) ? 1'b1 : (mode == 0 ? 1'b0 : 1'($urandom));
    cfg_label      = 3'($urandom);
    cfg_rfi_auto   = 1'($urandom);
    cfg_rfi_val    = 1'($urandom);
    cfg_rdi_sel    = (mode == 2) ? 2'b10 : 2'($urandom);
    cfg_rdi_val    = 1'($urandom);
    rx_rei_nonzero = 1'($urandom);
    rx_rfi_defect  = 1'($urandom);
    rx_rdi_defect  = 1'($urandom);
    rx_rdi_status  = 1'($urandom);
    trib_ais       = 1'($urandom);
    e_ais   = trib_ais;
    e_valid = in_valid;
    e_sof   = in_valid && in_sof;
    if (in_valid) begin
      if (in_sof) begin
        e_data = model_v5();
        sent_q.delete();
      end else e_data = in_data;
      sent_q.push_back(e_data);
      pos++;
      if (pos >= flen) begin pos = 0; flen = $urandom_range(3, 12); end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int pos = 3, flen = 8;
    rst_n = 1'b0;
    in_valid = 0; in_sof = 0; in_data = 0;
    cfg_bip_err = 0; cfg_label = 0; cfg_rfi_auto = 0; cfg_rfi_val = 0;
    cfg_rdi_sel = 0; cfg_rdi_val = 0; rx_rei_nonzero = 0; rx_rfi_defect = 0;
    rx_rdi_defect = 0; rx_rdi_status = 0; trib_ais = 0;
    e_valid = 0; e_sof = 0; e_ais = 0; e_data = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!out_valid && !out_sof && out_data == 0 && !ais_status, "R11 reset",
          {out_valid, out_sof, ais_status, out_data}, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      compare();
      // phases: normal parity, forced error, reserved RDI code, free random
      drive_and_model(c < 1000 ? 0 : c < 1600 ? 1 : c < 2000 ? 2 : 3, pos, flen);
    end
    @(negedge clk);
    compare();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule